// File: doc/BRIEF.md
# Page-Offset-Indexed, Physically-Tagged Level-1 Read Cache

This block is a 16 KB level-1 read cache holding 128 sets of four 32-byte lines. A requester presents only the low twelve bits of its address (the part that is the same before and after translation). The cache starts reading the chosen set at once, so the set read overlaps address translation. In the following cycle, or later if translation is slow, the translation unit supplies the 20-bit physical page number. The cache then compares that number against the four stored tags and returns the requested 32-bit word.

On a miss the cache issues one line-fill request to the next memory level and stalls new requests until the whole line comes back. It then writes the line into the chosen way and returns the requested word from it. The same request path can also invalidate a line: the requester marks the request as a kill, and the way whose tag matches the supplied page number is marked empty.

Top module: `vipt_l1_cache`

## Requirements
- R1: After reset every line is empty, `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0. The first read of any address is a miss.
- R2: Request offset bits 11:5 choose the set and bits 4:2 choose the word in the line. Bits 1:0 are always 0. Word k of a line sits in line bits 32k+31:32k. The tag is the full 20-bit page number.
- R3: A read whose page number matches a valid way in its set raises `resp_valid` with the word for one cycle. This happens at the clock edge that follows the cycle in which `xlat_valid` was high, and no memory request is made.
- R4: A read that matches no valid way produces one single-cycle `mem_req_valid` pulse at that same edge, with `mem_req_addr` = {page number, set, 5'b0}. At the edge that samples `mem_resp_valid`, the line is installed and `resp_valid` carries the requested word.
- R5: While an accepted request waits with `xlat_valid` low, no response and no memory request is produced, and `req_ready` stays 0.
- R6: From a miss until the fill returns, `req_ready` stays 0. At most one fill is outstanding.
- R7: A fill goes to the lowest-numbered empty way of the set. If the set is full, it goes to the pseudo-LRU victim from a 3-bit tree (t0, t1, t2) that resets to 0. If t0=0 the victim is way t1 (way 0 or 1); if t0=1 it is way 2+t2.
- R8: Every hit and every fill to way w updates the tree. For way 0: t0=1, t1=1. For way 1: t0=1, t1=0. For way 2: t0=0, t2=1. For way 3: t0=0, t2=0.
- R9: A request with `req_inv`=1 empties the way of that set whose tag equals the supplied page number. It gives no response and no memory request, and other lines keep hitting.
- R10: `mem_resp_valid` while no fill is outstanding has no effect on responses or cached contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_inv | input | 1 | 1: invalidate the line instead of reading |
| req_page_off | input | 12 | Untranslated page-offset address bits |
| xlat_valid | input | 1 | Translation for the pending request is available |
| xlat_ppn | input | 20 | Physical page number |
| resp_valid | output | 1 | Read data valid (one-cycle pulse) |
| resp_data | output | 32 | Read word |
| mem_req_valid | output | 1 | Line-fill request pulse |
| mem_req_addr | output | 32 | Line-aligned physical address of the fill |
| mem_resp_valid | input | 1 | Fill line present |
| mem_resp_line | input | 256 | Fill line, word 0 in the low bits |

## Verification
A wrong valid bit or a bad replacement-tree value stays hidden until the next access to that set. It then shows at the ports as an extra fill request where a hit was due, or as a missing one. For that reason the bench fills one set completely and checks which line was evicted through later hits and misses. A corrupt tag or word selection shows on `resp_data` at the first response. A control-state error shows within a cycle as a wrong `req_ready` or a response pulse with no cause.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;
  localparam int TREE_W = 3;

  typedef enum logic {ST_RUN, ST_FILL} ctl_state_e;

  // tree bit 0 picks the half, bits 1/2 pick inside each half
  function automatic logic [WAY_W-1:0] tree_victim(input logic [TREE_W-1:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  function automatic logic [TREE_W-1:0] tree_touch(input logic [TREE_W-1:0] t,
                                                   input logic [WAY_W-1:0] w);
    logic [TREE_W-1:0] n;
    n = t;
    if (w[1] == 1'b0) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction
endpackage

// File: rtl/vipt_way_ram.sv
module vipt_way_ram #(
  parameter int SET_W  = 7,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [SET_W-1:0]  rd_set,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line
);
  localparam int SETS = 1 << SET_W;

  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set]  <= wr_tag;
      line_mem[wr_set] <= wr_line;
    end
  end

  // synchronous read, held while rd_en is low
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag  <= tag_mem[rd_set];
      rd_line <= line_mem[rd_set];
    end
  end
endmodule

// File: rtl/vipt_set_state.sv
module vipt_set_state
  import vipt_pkg::*;
#(
  parameter int SET_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_i,
  output logic [WAYS-1:0]  valid_o,
  output logic [WAY_W-1:0] victim_o,
  input  logic             touch_en,
  input  logic             fill_en,
  input  logic             clr_en,
  input  logic [WAY_W-1:0] way_i
);
  localparam int SETS = 1 << SET_W;

  logic [WAYS-1:0]   valid_q [SETS];
  logic [TREE_W-1:0] tree_q  [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        tree_q[s]  <= '0;
      end
    end else begin
      if (touch_en) tree_q[set_i] <= tree_touch(tree_q[set_i], way_i);
      if (fill_en)  valid_q[set_i][way_i] <= 1'b1;
      else if (clr_en) valid_q[set_i][way_i] <= 1'b0;
    end
  end

  assign valid_o = valid_q[set_i];

  always_comb begin
    victim_o = tree_victim(tree_q[set_i]);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_o[w]) victim_o = WAY_W'(w);
    end
  end

  assert_fill_marks_valid_R4: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> valid_q[$past(set_i)][$past(way_i)]);
endmodule

// File: rtl/vipt_match.sv
module vipt_match
  import vipt_pkg::*;
#(
  parameter int TAG_W  = 20,
  parameter int LINE_W = 256,
  parameter int WORD_W = 32,
  parameter int WSEL_W = 3
) (
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [WAYS-1:0][LINE_W-1:0] lines_i,
  input  logic [WAYS-1:0]             valid_i,
  input  logic [TAG_W-1:0]            ppn_i,
  input  logic [WSEL_W-1:0]           wsel_i,
  output logic [WAYS-1:0]             match_o,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            way_o,
  output logic [WORD_W-1:0]           word_o
);
  logic [LINE_W-1:0] line_sel;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = valid_i[w] && (tags_i[w] == ppn_i);
  end

  assign hit_o = |match_o;

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_o[w]) way_o = WAY_W'(w);
    end
  end

  assign line_sel = lines_i[way_o];
  assign word_o   = line_sel[wsel_i*WORD_W +: WORD_W];
endmodule

// File: rtl/vipt_l1_cache.sv
module vipt_l1_cache
  import vipt_pkg::*;
#(
  parameter int PPN_W  = 20,
  parameter int SET_W  = 7,
  parameter int OFF_W  = 5,
  parameter int WORD_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_inv,
  input  logic [SET_W+OFF_W-1:0]    req_page_off,
  input  logic                      xlat_valid,
  input  logic [PPN_W-1:0]          xlat_ppn,
  output logic                      resp_valid,
  output logic [WORD_W-1:0]         resp_data,
  output logic                      mem_req_valid,
  output logic [PPN_W+SET_W+OFF_W-1:0] mem_req_addr,
  input  logic                      mem_resp_valid,
  input  logic [(8<<OFF_W)-1:0]     mem_resp_line
);
  localparam int LINE_W = 8 << OFF_W;
  localparam int BSEL_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BSEL_W;

  // stage 2 registers
  logic              s2_valid_q, s2_inv_q;
  logic [SET_W-1:0]  s2_set_q;
  logic [WSEL_W-1:0] s2_wsel_q;
  ctl_state_e        state_q;
  logic [PPN_W-1:0]  miss_ppn_q;
  logic [WAY_W-1:0]  miss_way_q;

  logic [WAYS-1:0][PPN_W-1:0]  way_tags;
  logic [WAYS-1:0][LINE_W-1:0] way_lines;
  logic [WAYS-1:0]   set_valid, hit_vec;
  logic [WAY_W-1:0]  victim, hit_way, upd_way;
  logic [WORD_W-1:0] hit_word;
  logic hit, accept, s2_go, s2_done, fill_now, rd_hit, rd_miss, inv_hit;

  assign accept   = req_valid && req_ready;
  assign s2_go    = s2_valid_q && (state_q == ST_RUN) && xlat_valid;
  assign rd_hit   = s2_go && !s2_inv_q && hit;
  assign rd_miss  = s2_go && !s2_inv_q && !hit;
  assign inv_hit  = s2_go && s2_inv_q && hit;
  assign s2_done  = s2_go && (s2_inv_q || hit);
  assign fill_now = (state_q == ST_FILL) && mem_resp_valid;
  assign req_ready = (state_q == ST_RUN) && (!s2_valid_q || s2_done);
  assign upd_way  = fill_now ? miss_way_q : hit_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    vipt_way_ram #(.SET_W(SET_W), .TAG_W(PPN_W), .LINE_W(LINE_W)) ram_i (
      .clk     (clk),
      .rd_en   (accept),
      .rd_set  (req_page_off[SET_W+OFF_W-1:OFF_W]),
      .wr_en   (fill_now && (miss_way_q == WAY_W'(w))),
      .wr_set  (s2_set_q),
      .wr_tag  (miss_ppn_q),
      .wr_line (mem_resp_line),
      .rd_tag  (way_tags[w]),
      .rd_line (way_lines[w])
    );
  end

  vipt_set_state #(.SET_W(SET_W)) state_i (
    .clk      (clk),
    .rst      (rst),
    .set_i    (s2_set_q),
    .valid_o  (set_valid),
    .victim_o (victim),
    .touch_en (rd_hit || fill_now),
    .fill_en  (fill_now),
    .clr_en   (inv_hit),
    .way_i    (upd_way)
  );

  vipt_match #(.TAG_W(PPN_W), .LINE_W(LINE_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)) match_i (
    .tags_i  (way_tags),
    .lines_i (way_lines),
    .valid_i (set_valid),
    .ppn_i   (xlat_ppn),
    .wsel_i  (s2_wsel_q),
    .match_o (hit_vec),
    .hit_o   (hit),
    .way_o   (hit_way),
    .word_o  (hit_word)
  );

  // control
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid_q    <= 1'b0;
      state_q       <= ST_RUN;
      resp_valid    <= 1'b0;
      mem_req_valid <= 1'b0;
    end else begin
      resp_valid    <= rd_hit || fill_now;
      mem_req_valid <= rd_miss;
      if (accept)                  s2_valid_q <= 1'b1;
      else if (s2_done || fill_now) s2_valid_q <= 1'b0;
      if (rd_miss)       state_q <= ST_FILL;
      else if (fill_now) state_q <= ST_RUN;
    end
  end

  // datapath
  always_ff @(posedge clk) begin
    if (accept) begin
      s2_inv_q  <= req_inv;
      s2_set_q  <= req_page_off[SET_W+OFF_W-1:OFF_W];
      s2_wsel_q <= req_page_off[OFF_W-1:BSEL_W];
    end
    if (rd_hit) resp_data <= hit_word;
    if (fill_now) resp_data <= mem_resp_line[s2_wsel_q*WORD_W +: WORD_W];
    if (rd_miss) begin
      miss_ppn_q   <= xlat_ppn;
      miss_way_q   <= victim;
      mem_req_addr <= {xlat_ppn, s2_set_q, {OFF_W{1'b0}}};
    end
  end

  assert_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_page_off[BSEL_W-1:0] == '0));
  assert_resp_cause_R3: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(xlat_valid || mem_resp_valid));
  assert_single_req_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  assert_tlb_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (s2_valid_q && !xlat_valid && state_q == ST_RUN) |=> (!resp_valid && !mem_req_valid));
  assert_hold_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL && !mem_resp_valid) |=> (state_q == ST_FILL && !resp_valid));
  assert_unique_tag_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: tb/vipt_l1_cache_tb.sv
module vipt_l1_cache_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_inv = 0, xlat_valid = 0, mem_resp_valid = 0;
  logic [11:0] req_page_off = '0;
  logic [19:0] xlat_ppn = '0;
  logic [255:0] mem_resp_line = '0;
  logic req_ready, resp_valid, mem_req_valid;
  logic [31:0] resp_data, mem_req_addr;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  vipt_l1_cache dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_inv(req_inv), .req_page_off(req_page_off), .xlat_valid(xlat_valid),
    .xlat_ppn(xlat_ppn), .resp_valid(resp_valid), .resp_data(resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_line(mem_resp_line)
  );

  function automatic logic [31:0] mk_word(input logic [31:0] a, input int k);
    return ({a[31:5], 5'b0} | 32'(k << 2)) ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [255:0] mk_line(input logic [31:0] a);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[k*32 +: 32] = mk_word(a, k);
    return l;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [19:0] ppn, input logic [11:0] off, input bit inv, input int tlb_wait);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_inv = inv; req_page_off = off;
    @(negedge clk);
    req_valid = 0; req_inv = 0;
    for (int i = 0; i < tlb_wait; i++) begin
      check(!req_ready && !resp_valid && !mem_req_valid, "R5 stall", {req_ready, resp_valid, mem_req_valid}, 0);
      @(negedge clk);
    end
    xlat_valid = 1; xlat_ppn = ppn;
    @(negedge clk);
    xlat_valid = 0;
  endtask

  // read one word; exp_miss decides whether a fill must appear
  task automatic do_read(input logic [19:0] ppn, input logic [11:0] off, input int tlb_wait,
                         input bit exp_miss, input string rq);
    logic [31:0] la, raddr;
    int nreq = 0, cnt = 0, lat = -1;
    la = {ppn, off[11:5], 5'b0};
    raddr = '0;
    send(ppn, off, 1'b0, tlb_wait);
    for (int c = 0; c < 40; c++) begin
      mem_resp_valid = 0;
      if (resp_valid) begin lat = c; break; end
      if (mem_req_valid) begin
        nreq++; raddr = mem_req_addr; cnt = 2;
        check(!req_ready, "R6 ready low during fill", req_ready, 0);
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin mem_resp_valid = 1; mem_resp_line = mk_line(raddr); end
      end
      @(negedge clk);
    end
    mem_resp_valid = 0;
    check(lat >= 0, {rq, " response"}, lat, 0);
    check(resp_data == mk_word(la, int'(off[4:2])), {rq, " data R2"}, resp_data, mk_word(la, int'(off[4:2])));
    check(nreq == (exp_miss ? 1 : 0), {rq, " fill count"}, nreq, exp_miss);
    if (exp_miss) check(raddr == la, {rq, " fill address R4"}, raddr, la);
    else check(lat == 0, {rq, " hit latency R3"}, lat, 0);
  endtask

  task automatic t_reset;
    check(req_ready && !resp_valid && !mem_req_valid, "R1 reset outputs", {req_ready, resp_valid, mem_req_valid}, 3'b100);
  endtask

  task automatic t_cold_and_hit;
    do_read(20'hAAAAA, 12'h0A4, 0, 1, "R1 R4 cold miss");
    do_read(20'hAAAAA, 12'h0BC, 0, 0, "R3 hit word 7");
    do_read(20'hAAAAA, 12'h0A0, 0, 0, "R3 hit word 0");
    do_read(20'hAAAAA, 12'hC84, 0, 1, "R4 other set miss");
  endtask

  task automatic t_tlb_stall;
    do_read(20'hAAAAA, 12'h0A8, 3, 0, "R5 slow translation hit");
    do_read(20'h12345, 12'h0A8, 2, 1, "R5 slow translation miss");
  endtask

  // set 5 now holds AAAAA (way 0) and 12345 (way 1)
  task automatic t_replace;
    do_read(20'h0000C, 12'h0B0, 0, 1, "R7 fill way 2");
    do_read(20'h0000D, 12'h0B0, 0, 1, "R7 fill way 3");
    do_read(20'h12345, 12'h0A0, 0, 0, "R8 touch way 1");
    do_read(20'h0000C, 12'h0A0, 0, 0, "R8 touch way 2");
    do_read(20'h0000D, 12'h0A0, 0, 0, "R8 touch way 3");
    do_read(20'hAAAAA, 12'h0A0, 0, 0, "R8 touch way 0");
    do_read(20'h0000E, 12'h0A4, 0, 1, "R7 evict tree victim");
    do_read(20'h0000E, 12'h0A8, 0, 0, "R7 new line hits");
    do_read(20'hAAAAA, 12'h0A8, 0, 0, "R7 way 0 kept");
    do_read(20'h12345, 12'h0A8, 0, 0, "R7 way 1 kept");
    do_read(20'h0000D, 12'h0A8, 0, 0, "R7 way 3 kept");
    do_read(20'h0000C, 12'h0A8, 0, 1, "R7 evicted line misses");
  endtask

  task automatic t_invalidate;
    int bad = 0;
    send(20'h12345, 12'h0A0, 1'b1, 0);
    for (int c = 0; c < 6; c++) begin
      if (resp_valid || mem_req_valid) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R9 invalidate silent", bad, 0);
    do_read(20'h0000D, 12'h0AC, 0, 0, "R9 neighbour still hits");
    do_read(20'h12345, 12'h0AC, 0, 1, "R9 invalidated line misses");
  endtask

  task automatic t_spurious;
    mem_resp_valid = 1; mem_resp_line = {8{32'hDEAD_BEEF}};
    @(negedge clk);
    mem_resp_valid = 0;
    check(!resp_valid, "R10 stray fill no response", resp_valid, 0);
    do_read(20'h0000D, 12'h0B8, 0, 0, "R10 contents unchanged");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cold_and_hit();
    t_tlb_stall();
    t_replace();
    t_invalidate();
    t_spurious();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule